// File: doc/BRIEF.md
# Double-Buffered PWM Comparison Unit

This block watches the 16-bit counter of a reference PWM channel and emits a one-clock match pulse when that counter reaches a programmed compare value. The match can be restricted to the rising or the falling half of a center-aligned period, according to a direction-mode bit. When the reference channel counts up only (left-aligned), the direction-mode bit is disregarded.

Software never writes the live compare settings. A write to the value-update register fills a shadow buffer with a new compare value and direction-mode bit. A later write to the separate mode-update register arms a pending flag. The buffered settings then move into the active compare logic on the next period-boundary strobe. Because of this, a half-finished reprogramming sequence can never produce a stray match.

Top module: `pwm_cmp_unit`

## Requirements
- R1: After reset, the active compare value and the buffered value are 0, the active mode is "incrementing", no update is pending and `match_o` is low.
- R2: A value-update write (`wr_en_i`=1, `wr_sel_i`=0) that is not followed by a mode-update write never changes the active compare settings, no matter how many period strobes pass.
- R3: A mode-update write (`wr_en_i`=1, `wr_sel_i`=1) arms a pending update. On the next cycle with `period_strobe_i`=1, the buffered settings become active and the pending flag clears. A match evaluated on that same strobe cycle still uses the previous active settings.
- R4: In the value-update word, only bits 15:0 form the compare value. Bits 23:16 and bits 31:25 have no effect.
- R5: With the active mode bit (word bit 24) equal to 0 and `left_align_i`=0, a match is recognised only while `cnt_down_i`=0 (incrementing).
- R6: With the active mode bit equal to 1 and `left_align_i`=0, a match is recognised only while `cnt_down_i`=1 (decrementing).
- R7: With `left_align_i`=1, the direction-mode bit and `cnt_down_i` have no effect. A match occurs whenever the counter equals the active value.
- R8: A second value-update write before the mode-update write replaces the first in the buffer. Only the newer settings are committed.
- R9: `match_o` rises in the clock cycle after the cycle in which the sampled counter equals the active value with the direction qualified. It lasts one cycle. It fires at most once per counting direction between period strobes, even if the counter holds the value for several cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | Write target: 0 value-update, 1 mode-update |
| wr_data_i | input | 32 | Write data (value-update: bits 15:0 value, bit 24 mode) |
| cnt_i | input | 16 | Reference channel counter |
| cnt_down_i | input | 1 | Counter direction: 1 decrementing |
| left_align_i | input | 1 | Reference channel counts up only |
| period_strobe_i | input | 1 | Counter period boundary |
| match_o | output | 1 | Compare match pulse |

## Verification
The assertions assume that `left_align_i` stays constant within a period. They also assume that the counter moves by one step per cycle or holds, so it cannot revisit the compare value in the opposite direction within one cycle of a match. They further assume that the period strobe marks a wrap point whose counter value differs from the value of the cycle before. The bench drives only clean triangular center-aligned sweeps and ramp left-aligned sweeps that meet these assumptions. It holds the counter at an unused value (0xFFFF) during register writes. It switches alignment only at a period strobe.

// File: rtl/pwm_cmp_pkg.sv
package pwm_cmp_pkg;
    localparam int unsigned CMP_CNT_W    = 16;
    localparam int unsigned CMP_BUS_W    = 32;
    localparam int unsigned CMP_MODE_BIT = 24;

    typedef enum logic {
        WSEL_VALUE = 1'b0,
        WSEL_MODE  = 1'b1
    } wr_sel_e;
endpackage

// File: rtl/pwm_cmp_shadow.sv
module pwm_cmp_shadow #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             val_wr_i,
    input  logic [CNT_W-1:0] val_i,
    input  logic             mode_i,
    input  logic             mode_wr_i,
    input  logic             period_strobe_i,
    output logic [CNT_W-1:0] act_val_o,
    output logic             act_down_o,
    output logic             pending_o
);
    typedef struct packed {
        logic [CNT_W-1:0] buf_val;
        logic             buf_down;
        logic             pend;
        logic [CNT_W-1:0] act_val;
        logic             act_down;
    } shadow_t;

    shadow_t st_d, st_q;
    logic    commit;

    always_comb begin
        st_d   = st_q;
        commit = st_q.pend && period_strobe_i;
        if (commit) begin
            st_d.act_val  = st_q.buf_val;
            st_d.act_down = st_q.buf_down;
            st_d.pend     = 1'b0;
        end
        if (val_wr_i) begin
            st_d.buf_val  = val_i;
            st_d.buf_down = mode_i;
        end
        if (mode_wr_i) begin
            st_d.pend = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign act_val_o  = st_q.act_val;
    assign act_down_o = st_q.act_down;
    assign pending_o  = st_q.pend;

    // R2: active settings only move on a commit
    p_hold_active_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(pending_o && period_strobe_i) |=> ($stable(act_val_o) && $stable(act_down_o)));

    // R3: a mode-update write arms the pending flag
    p_mode_arms_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mode_wr_i |=> pending_o);

    // R3: a boundary with an armed update clears it
    p_commit_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pending_o && period_strobe_i && !mode_wr_i) |=> !pending_o);
endmodule

// File: rtl/pwm_cmp_match.sv
module pwm_cmp_match #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             cnt_down_i,
    input  logic             left_align_i,
    input  logic             period_strobe_i,
    input  logic [CNT_W-1:0] act_val_i,
    input  logic             act_down_i,
    output logic             match_o
);
    typedef struct packed {
        logic fired_up;
        logic fired_dn;
        logic match;
    } match_t;

    match_t mt_d, mt_q;
    logic   dir_dn, dir_ok, equal, hit, base_up, base_dn, already;

    always_comb begin
        mt_d    = mt_q;
        dir_dn  = !left_align_i && cnt_down_i;
        dir_ok  = left_align_i || (cnt_down_i == act_down_i);
        equal   = (cnt_i == act_val_i);
        hit     = equal && dir_ok;
        base_up = period_strobe_i ? 1'b0 : mt_q.fired_up;
        base_dn = period_strobe_i ? 1'b0 : mt_q.fired_dn;
        already = dir_dn ? base_dn : base_up;
        mt_d.match    = hit && !already;
        mt_d.fired_up = base_up || (mt_d.match && !dir_dn);
        mt_d.fired_dn = base_dn || (mt_d.match && dir_dn);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mt_q <= '0;
        else        mt_q <= mt_d;
    end

    assign match_o = mt_q.match;

    // R6: in center mode a pulse follows a sample taken in the active direction
    p_dir_qual_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (match_o && !$past(left_align_i)) |-> ($past(cnt_down_i) == $past(act_down_i)));

    // R9: a pulse is one cycle long
    p_single_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        match_o |=> !match_o);

    // R9: a pulse needs the counter at the compare value one cycle earlier
    p_equal_before_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(match_o) |-> ($past(cnt_i) == $past(act_val_i)));
endmodule

// File: rtl/pwm_cmp_unit.sv
module pwm_cmp_unit
    import pwm_cmp_pkg::*;
#(
    parameter int unsigned CNT_W    = CMP_CNT_W,
    parameter int unsigned BUS_W    = CMP_BUS_W,
    parameter int unsigned MODE_BIT = CMP_MODE_BIT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic             wr_sel_i,
    input  logic [BUS_W-1:0] wr_data_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             cnt_down_i,
    input  logic             left_align_i,
    input  logic             period_strobe_i,
    output logic             match_o
);
    logic             val_wr, mode_wr, act_down, pending;
    logic [CNT_W-1:0] val, act_val;
    logic             mode_bit;

    always_comb begin
        val_wr   = wr_en_i && (wr_sel_e'(wr_sel_i) == WSEL_VALUE);
        mode_wr  = wr_en_i && (wr_sel_e'(wr_sel_i) == WSEL_MODE);
        val      = wr_data_i[CNT_W-1:0];
        mode_bit = wr_data_i[MODE_BIT];
    end

    pwm_cmp_shadow #(.CNT_W(CNT_W)) u_shadow (
        .clk             (clk),
        .rst_n           (rst_n),
        .val_wr_i        (val_wr),
        .val_i           (val),
        .mode_i          (mode_bit),
        .mode_wr_i       (mode_wr),
        .period_strobe_i (period_strobe_i),
        .act_val_o       (act_val),
        .act_down_o      (act_down),
        .pending_o       (pending)
    );

    pwm_cmp_match #(.CNT_W(CNT_W)) u_match (
        .clk             (clk),
        .rst_n           (rst_n),
        .cnt_i           (cnt_i),
        .cnt_down_i      (cnt_down_i),
        .left_align_i    (left_align_i),
        .period_strobe_i (period_strobe_i),
        .act_val_i       (act_val),
        .act_down_i      (act_down),
        .match_o         (match_o)
    );

    // R7: in left-aligned counting a pulse needs only equality
    p_left_equal_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (match_o && $past(left_align_i)) |-> ($past(cnt_i) == $past(act_val)));

    // R1: nothing is pending out of reset until a mode-update write
    p_no_pending_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(pending)) |-> $past(mode_wr));
endmodule

// File: tb/pwm_cmp_unit_bench.sv
module pwm_cmp_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, wr_sel = 1'b0;
    logic [31:0] wr_data = '0;
    logic [15:0] cnt = 16'hFFFF;
    logic        cnt_down = 1'b0, left_align = 1'b0, strobe = 1'b0;
    logic        match;

    int n_tests = 0, n_fail = 0;
    bit done = 0;

    // bench model
    logic [15:0] m_buf_v = '0, m_act_v = '0;
    logic        m_buf_m = 0, m_act_m = 0, m_pend = 0, f_up = 0, f_dn = 0;

    always #4 clk = ~clk;

    pwm_cmp_unit u_pwm_cmp_unit (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
        .wr_data_i(wr_data), .cnt_i(cnt), .cnt_down_i(cnt_down),
        .left_align_i(left_align), .period_strobe_i(strobe), .match_o(match)
    );

    task automatic check(input string tag, input logic act, input logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: match_o=%0b expected %0b (cnt=%0d dn=%0b left=%0b)",
                     tag, act, exp, cnt, cnt_down, left_align);
        end
    endtask

    task automatic cyc(input string tag, input logic we, input logic sel,
                       input logic [31:0] data, input logic [15:0] c,
                       input logic dn, input logic stb);
        logic exp, dd;
        @(negedge clk);
        wr_en = we; wr_sel = sel; wr_data = data;
        cnt = c; cnt_down = dn; strobe = stb;
        @(posedge clk);
        if (stb) begin f_up = 0; f_dn = 0; end
        dd  = !left_align && dn;
        exp = (c == m_act_v) && (left_align || (dn == m_act_m)) && !(dd ? f_dn : f_up);
        if (exp) begin if (dd) f_dn = 1; else f_up = 1; end
        if (stb && m_pend) begin m_act_v = m_buf_v; m_act_m = m_buf_m; m_pend = 0; end
        if (we && !sel) begin m_buf_v = data[15:0]; m_buf_m = data[24]; end
        if (we && sel) m_pend = 1;
        #1 check(tag, match, exp);
    endtask

    task automatic wr_val(input string tag, input logic [31:0] d);
        cyc(tag, 1, 0, d, 16'hFFFF, 0, 0);
    endtask
    task automatic wr_mode(input string tag);
        cyc(tag, 1, 1, 32'h0, 16'hFFFF, 0, 0);
    endtask

    task automatic period(input string tag, input int top);
        if (left_align) begin
            for (int i = 0; i <= top; i++) cyc(tag, 0, 0, 0, 16'(i), 0, i == 0);
        end else begin
            for (int i = 0; i < top; i++) cyc(tag, 0, 0, 0, 16'(i), 0, i == 0);
            for (int i = top; i > 0; i--) cyc(tag, 0, 0, 0, 16'(i), 1, 0);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 check("R1 reset", match, 1'b0);
        @(negedge clk) rst_n = 1'b1;
        period("R1 default value 0 incrementing", 8);

        wr_val("R2", 32'h0000_0005);
        period("R2 no commit without mode write", 8);
        period("R2 no commit without mode write", 8);

        wr_mode("R3");
        period("R3 commit at boundary", 8);
        period("R3 new value active", 8);

        wr_val("R4", 32'hFEAB_0003);
        wr_mode("R4");
        period("R4 upper bits ignored", 8);
        period("R4 upper bits ignored", 8);

        wr_val("R6", 32'h0100_0006);
        wr_mode("R6");
        period("R6 decrement only", 8);
        period("R6 decrement only", 8);

        wr_val("R8", 32'h0000_0002);
        wr_val("R8", 32'h0000_0004);
        wr_mode("R8");
        period("R8 newer value wins", 8);
        period("R5 increment only", 8);

        // near-exhaustive sweep: every value in a small period, both modes
        for (int m = 0; m < 2; m++)
            for (int v = 0; v <= 8; v++) begin
                wr_val("R5/R6 sweep", (32'(m) << 24) | 32'(v));
                wr_mode("R5/R6 sweep");
                period("R5/R6 sweep", 8);
                period("R5/R6 sweep", 8);
            end

        // left aligned: mode bit ignored
        wr_val("R7", 32'h0100_0005);
        wr_mode("R7");
        period("R7 commit", 8);
        @(negedge clk) left_align = 1'b1;
        period("R7 left-aligned ignores mode", 10);
        for (int v = 0; v <= 10; v++) begin
            wr_val("R7 sweep", 32'h0100_0000 | 32'(v));
            wr_mode("R7 sweep");
            period("R7 sweep", 10);
            period("R7 sweep", 10);
        end

        // hold counter at compare value: one pulse only
        wr_val("R9", 32'h0000_0005);
        wr_mode("R9");
        period("R9", 10);
        cyc("R9 hold", 0, 0, 0, 16'd0, 0, 1);
        cyc("R9 first pulse", 0, 0, 0, 16'd5, 0, 0);
        cyc("R9 held no repeat", 0, 0, 0, 16'd5, 0, 0);
        cyc("R9 held no repeat", 0, 0, 0, 16'd5, 0, 0);
        cyc("R9 after hold", 0, 0, 0, 16'd6, 0, 0);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule